// File: doc/BRIEF.md
# Edge Interrupt Pending Unit

The unit watches a parallel input port and turns selected signal edges into latched per-pin pending flags. Each pin is first brought into the clock domain by a two-stage synchroniser; a transition between two consecutive synchronised samples counts as an edge when its direction matches that pin's polarity setting. A detected edge sets the pin's pending flag. The flags stay set until software clears them.

A single level interrupt request is raised toward a processor with one interrupt vector. The request stays high as long as any pending flag whose enable bit is set remains set. Software services the unit with an atomic exchange. The exchange returns the pending word as it was before the access and clears only the bits named in the write mask. An edge detected in the same cycle always survives the exchange, whether it lands on the pin being cleared or on another pin. Edges that arrive while the service routine runs therefore raise a new request after it returns.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset the pending word is zero, the enable mask is zero, every pin's polarity is rising, `irqReq` is 0 and `busRdata` is 0.
- R2: With polarity bit 0, a 0-to-1 change on a pin sets that pin's pending bit at the third rising clock edge after the input change: two synchroniser flops plus one sample register. It is not set earlier.
- R3: With polarity bit 1, a 1-to-0 change sets the pending bit and a 0-to-1 change does not. With polarity 0, a 1-to-0 change does not set it.
- R4: Edges detected on several pins in the same cycle are all recorded.
- R5: An exchange (`busOp` = 2'b11) loads `busRdata` at that clock edge with the pending word as it was before the access. `busRdata` holds that value until the next exchange.
- R6: An exchange clears exactly the pending bits where `busWdata` is 1. Pending bits are never cleared by any other operation.
- R7: A bit whose edge is detected in the same cycle as an exchange is set afterwards, even when the mask clears that bit. This holds equally when the mask clears a different pin.
- R8: `irqReq` is 1 exactly when some pending bit and its enable bit are both 1. It stays 1 until an exchange clears the cause or the enable mask changes.
- R9: Writing the enable mask (`busOp` = 2'b01, value on `busWdata`) does not alter stored pending bits. Writing polarity (`busOp` = 2'b10, bit 1 = falling) does not alter them either.
- R10: `busOp` = 2'b00 is idle. It changes no register other than recording new edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Asynchronous input port pins |
| busOp | input | 2 | 00 idle, 01 write enable, 10 write polarity, 11 exchange |
| busWdata | input | NUM_PINS | Enable or polarity value, or clear mask for an exchange |
| busRdata | output | NUM_PINS | Pending word captured by the last exchange |
| irqReq | output | 1 | Level interrupt request |

## Verification
A wrong pending bit shows up at `irqReq` in the same cycle if that pin is enabled. Whether or not it is enabled, the next exchange returns it on `busRdata` one edge later. A lost edge during a simultaneous clear is therefore visible at the first read after the collision cycle. The bench aims exchanges at the exact cycle in which fresh edges are detected, so that kind of collision actually occurs. A cycle-accurate bench model compares both outputs on every cycle, so a synchroniser depth or polarity error shows up as a one-cycle timing mismatch or a wrong bit.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE         = 2'b00,
    OP_SET_ENABLE   = 2'b01,
    OP_SET_POLARITY = 2'b10,
    OP_EXCHANGE     = 2'b11
  } busOp_e;

  typedef struct packed {
    logic loadEnable;
    logic loadPolarity;
    logic exchange;
  } ctrlStrobes_t;

endpackage

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   busOp,
  output ctrlStrobes_t strobes
);

  busOp_e opDecoded;

  always_comb begin
    opDecoded = busOp_e'(busOp);
    strobes   = '0;
    unique case (opDecoded)
      OP_SET_ENABLE:   strobes.loadEnable   = 1'b1;
      OP_SET_POLARITY: strobes.loadPolarity = 1'b1;
      OP_EXCHANGE:     strobes.exchange     = 1'b1;
      default:         strobes              = '0;
    endcase
  end

  // R10: at most one register action per cycle
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.loadEnable, strobes.loadPolarity, strobes.exchange}));

  // R10: idle code raises no strobe
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busOp == 2'b00) |-> (strobes == '0));

endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  ctrlStrobes_t        strobes,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  output logic                irqReq
);

  localparam int LastStage = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncPipe;
  logic [NUM_PINS-1:0] syncOut;
  logic [NUM_PINS-1:0] prevSample;
  logic [NUM_PINS-1:0] polarityReg;
  logic [NUM_PINS-1:0] enableReg;
  logic [NUM_PINS-1:0] pendingReg;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] clearMask;
  logic [NUM_PINS-1:0] nextPending;

  // Synchroniser chain, one lane per pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncPipe   <= '0;
      prevSample <= '0;
    end else begin
      syncPipe   <= {syncPipe[LastStage-1:0], pinIn};
      prevSample <= syncOut;
    end
  end

  assign syncOut = syncPipe[LastStage];

  // Per-pin edge detector; polarity bit 1 selects falling
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_edge
    assign edgeHit[p] = polarityReg[p] ? (prevSample[p] & ~syncOut[p])
                                       : (~prevSample[p] & syncOut[p]);
  end

  // Bitwise clear, set dominates
  always_comb begin
    clearMask   = strobes.exchange ? busWdata : '0;
    nextPending = (pendingReg & ~clearMask) | edgeHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendingReg  <= '0;
      enableReg   <= '0;
      polarityReg <= '0;
      busRdata    <= '0;
    end else begin
      pendingReg <= nextPending;
      if (strobes.exchange)     busRdata    <= pendingReg;
      if (strobes.loadEnable)   enableReg   <= busWdata;
      if (strobes.loadPolarity) polarityReg <= busWdata;
    end
  end

  assign irqReq = |(pendingReg & enableReg);

  // R2: every detected edge is recorded at the next edge (also R4, R7)
  p_edge_recorded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeHit != '0) |=> ((pendingReg & $past(edgeHit)) == $past(edgeHit)));

  // R5: exchange returns the word held before the access
  p_xchg_returns_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.exchange |=> (busRdata == $past(pendingReg)));

  // R6: bits outside the clear mask survive an exchange
  p_unmasked_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.exchange |=>
      ((pendingReg & $past(pendingReg & ~busWdata)) == $past(pendingReg & ~busWdata)));

  // R9: non-exchange cycles never drop a pending bit
  p_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.exchange |=> ((pendingReg & $past(pendingReg)) == $past(pendingReg)));

  // R8: request holds while nothing can remove its cause
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq && !strobes.exchange && !strobes.loadEnable) |=> irqReq);

  // R5: readback only moves on an exchange
  p_rdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.exchange |=> $stable(busRdata));

endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [1:0]          busOp,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  output logic                irqReq
);

  ctrlStrobes_t strobes;

  edge_irq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busOp   (busOp),
    .strobes (strobes)
  );

  edge_irq_datapath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinIn    (pinIn),
    .strobes  (strobes),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqReq   (irqReq)
  );

endmodule

// File: tb/tb_edge_irq_unit.sv
`timescale 1ns/1ps
module tb_edge_irq_unit;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] pinIn = '0;
  logic [1:0] busOp = 2'b00;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] busRdata;
  logic irqReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .busOp(busOp),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq)
  );

  // Reference model built from the requirements
  logic [W-1:0] mS1 = '0, mS2 = '0, mPrev = '0;
  logic [W-1:0] mPol = '0, mEn = '0, mPend = '0, mRd = '0;

  function automatic logic [W-1:0] edgesOf(logic [W-1:0] cur, logic [W-1:0] prv,
                                           logic [W-1:0] pol);
    return (~pol & cur & ~prv) | (pol & ~cur & prv);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mS1 <= '0; mS2 <= '0; mPrev <= '0;
      mPol <= '0; mEn <= '0; mPend <= '0; mRd <= '0;
    end else begin
      if (busOp == 2'b11) begin
        mRd   <= mPend;
        mPend <= (mPend & ~busWdata) | edgesOf(mS2, mPrev, mPol);
      end else begin
        mPend <= mPend | edgesOf(mS2, mPrev, mPol);
      end
      if (busOp == 2'b01) mEn  <= busWdata;
      if (busOp == 2'b10) mPol <= busWdata;
      mPrev <= mS2;
      mS2   <= mS1;
      mS1   <= pinIn;
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 irq level", {7'd0, irqReq}, {7'd0, |(mPend & mEn)});
      check("R5 readback", busRdata, mRd);
    end
  end

  task automatic doOp(logic [1:0] op, logic [W-1:0] wd);
    busOp = op; busWdata = wd;
    @(negedge clk);
    busOp = 2'b00; busWdata = '0;
  endtask

  task automatic readPend(output logic [W-1:0] v);
    doOp(2'b11, '0);
    v = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] v;
    int seedDummy;
    seedDummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", {7'd0, irqReq}, 8'h00);
    check("R1 rdata after reset", busRdata, 8'h00);
    readPend(v);
    check("R1 pending after reset", v, 8'h00);

    // R1 rising polarity default, R2 exact latency (enable code 01, R10)
    doOp(2'b01, 8'hFF);
    pinIn[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 not yet after two edges", {7'd0, irqReq}, 8'h00);
    @(negedge clk);
    check("R2 set at third edge", {7'd0, irqReq}, 8'h01);
    readPend(v);
    check("R2 pending bit0", v, 8'h01);
    repeat (3) @(negedge clk);
    check("R8 irq held while pending", {7'd0, irqReq}, 8'h01);
    doOp(2'b11, 8'h01);
    check("R6 cleared word returned", busRdata, 8'h01);

    // R3 polarity: pin1 falling, pin0 fall ignored under rising
    doOp(2'b10, 8'h02);
    pinIn[1] = 1'b1; settle();
    readPend(v);
    check("R3 rise ignored on falling pin", v, 8'h00);
    pinIn[1] = 1'b0; pinIn[0] = 1'b0; settle();
    readPend(v);
    check("R3 fall recorded only on falling pin", v, 8'h02);
    doOp(2'b11, 8'hFF);

    // R9 enable and polarity writes keep pending
    doOp(2'b10, 8'h00);
    pinIn[6] = 1'b1; settle();
    doOp(2'b01, 8'h00);
    check("R8 masked pin gives no irq", {7'd0, irqReq}, 8'h00);
    doOp(2'b10, 8'hFF);
    readPend(v);
    check("R9 pending kept over mask writes", v, 8'h40);
    doOp(2'b01, 8'h40);
    check("R8 unmask raises irq", {7'd0, irqReq}, 8'h01);
    doOp(2'b10, 8'h00);
    doOp(2'b11, 8'hFF);
    check("R6 full clear drops irq", {7'd0, irqReq}, 8'h00);

    // R4 simultaneous edges on unrelated pins
    pinIn[3] = 1'b1; pinIn[7] = 1'b1; settle();
    readPend(v);
    check("R4 both pins recorded", v, 8'h88);
    doOp(2'b11, 8'hFF);

    // R7 exchange in the edge-detect cycle: pin5 pending, edges on 2 and 4
    pinIn[5] = 1'b1; settle();
    pinIn[2] = 1'b1; pinIn[4] = 1'b1;
    @(negedge clk); @(negedge clk);
    doOp(2'b11, 8'h24);
    check("R5 exchange returns old word", busRdata, 8'h20);
    readPend(v);
    check("R7 set wins, other pin kept", v, 8'h14);
    doOp(2'b11, 8'hFF);

    // R10 idle cycles change nothing
    repeat (5) @(negedge clk);
    readPend(v);
    check("R10 idle keeps pending empty", v, 8'h00);

    // Random phase checked by the per-cycle model compare
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 3) == 0) pinIn = pinIn ^ W'($urandom & $urandom);
      busOp    = 2'($urandom % 4);
      busWdata = W'($urandom);
      @(negedge clk);
    end
    busOp = 2'b00; busWdata = '0;
    settle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule